// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit gathers four single-cycle event indications from a display controller into a sticky raw pending register. Software sees that register through a 32-bit word-addressed register port. Software can acknowledge pending bits by writing ones to a clear location. It can choose which pending bits may interrupt by writing an enable mask, and it can read the pending bits that pass the mask. A single level interrupt line reports whether any enabled bit is pending.

The line is a pure function of the stored pending and mask registers. Any edge that changes either register therefore moves the line at that same edge. This includes a new event, an acknowledge, or a mask rewrite. Enabling a bit that is already pending raises the line at once. Disabling the last enabled pending bit drops it at once. When an event and an acknowledge of the same bit meet in one cycle, the event is kept, so no occurrence is lost.

Reads are combinational from the current register contents. Writes take effect at the rising clock edge on which `reg_wr` is sampled high.

Top module: `irq_status_unit`

## Requirements
- R1: Each input event bit sets the pending bit of the same index at the rising edge where it is sampled high, and that bit then stays set until cleared. The indices are: bit 0 DMA frame end, bit 1 bus error, bit 2 vertical sync, bit 3 underrun.
- R2: Reads decode byte offsets as follows. 0x10 returns the pending bits and 0x18 returns the mask. 0x1C returns the masked pending bits. 0x14 and every other offset read as zero.
- R3: The masked status read at 0x1C equals the pending bits ANDed with the mask.
- R4: A write to 0x14 clears, at that edge, every pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R5: If an event bit is high in the same cycle as a clear write that targets the same bit, the pending bit ends up set.
- R6: `irq_o` is high exactly when at least one pending bit is also enabled in the mask.
- R7: A write to 0x18 loads data bits 3:0 into the mask at that edge, and `irq_o` reflects the new mask immediately after that edge.
- R8: After reset the pending bits and the mask are zero and `irq_o` is low. Bits 31:4 of every read are zero, whatever value was written.
- R9: Writes to offsets 0x10 and 0x1C change neither the pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 4 | Event indications, one per pending bit |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every stored effect is due one edge after its stimulus. This covers an event setting a bit, a clear, and a mask write. `irq_o` and the read data follow in that same cycle with no further register stage. The bench therefore drives inputs on a falling edge and waits for the next falling edge before it compares anything. At that point exactly one rising edge has passed, so each read and line check sees the state after that one edge. For the same-cycle set and clear case, both stimuli are driven in one falling-edge slot and the pending bit is checked one edge later.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_EVT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_ACK  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_MSTS = ADDR_W'('h1C);
  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] pend_q, mask_q, ack_bits, live;
  logic ack_wr, mask_wr;
  logic unused_hi;

  assign ack_wr    = reg_wr && (reg_addr == OFS_ACK);
  assign mask_wr   = reg_wr && (reg_addr == OFS_MASK);
  assign ack_bits  = ack_wr ? reg_wdata[NUM_EVT-1:0] : '0;
  assign live      = pend_q & mask_q;
  assign irq_o     = |live;
  assign unused_hi = ^reg_wdata[DATA_W-1:NUM_EVT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_bits) | evt_i;
      if (mask_wr) mask_q <= reg_wdata[NUM_EVT-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_PEND: reg_rdata = {{PAD_W{1'b0}}, pend_q};
      OFS_MASK: reg_rdata = {{PAD_W{1'b0}}, mask_q};
      OFS_MSTS: reg_rdata = {{PAD_W{1'b0}}, live};
      default:  reg_rdata = '0;
    endcase
  end

  // R1 R5
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((pend_q & $past(reg_wdata[NUM_EVT-1:0]) & ~$past(evt_i)) == '0));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && evt_i == '0) |=> $stable(pend_q));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(reg_wdata[NUM_EVT-1:0])));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr && evt_i == '0) |=> !$rose(irq_o));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] evt_i = '0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_status_unit dut_i (.clk, .rst_n, .evt_i, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .irq_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(logic [3:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    check("R8 irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R8 pend", 12'h10, 32'h0);
    rd_chk("R8 mask", 12'h18, 32'h0);
    rd_chk("R8 msts", 12'h1C, 32'h0);
  endtask

  task automatic t_positions;
    pulse(4'b0001); rd_chk("R1 dma end bit0", 12'h10, 32'h1);
    pulse(4'b0100); rd_chk("R1 vsync bit2", 12'h10, 32'h5);
    check("R6 irq masked off", {31'b0, irq_o}, 32'h0);
    pulse(4'b1000); rd_chk("R1 underrun bit3", 12'h10, 32'hD);
    pulse(4'b0010); rd_chk("R1 bus error bit1", 12'h10, 32'hF);
    rd_chk("R2 ack reads zero", 12'h14, 32'h0);
    rd_chk("R2 unused offset", 12'h20, 32'h0);
    rd_chk("R2 offset zero", 12'h00, 32'h0);
  endtask

  task automatic t_mask;
    wr(12'h18, 32'h4);
    check("R7 irq on mask enable", {31'b0, irq_o}, 32'h1);
    rd_chk("R3 msts", 12'h1C, 32'h4);
    wr(12'h18, 32'hFFFF_FFF9);
    rd_chk("R8 mask upper zero", 12'h18, 32'h9);
    rd_chk("R3 msts 9", 12'h1C, 32'h9);
    wr(12'h18, 32'h0);
    check("R7 irq drop on mask clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_clear;
    wr(12'h18, 32'hF);
    wr(12'h14, 32'h5);
    rd_chk("R4 partial clear", 12'h10, 32'hA);
    check("R6 irq still up", {31'b0, irq_o}, 32'h1);
    wr(12'h14, 32'hFFFF_FFFA);
    rd_chk("R4 full clear", 12'h10, 32'h0);
    check("R6 irq down", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_set_wins;
    pulse(4'b0001);
    @(negedge clk);
    evt_i = 4'b1000; reg_addr = 12'h14; reg_wdata = 32'h9; reg_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
    rd_chk("R5 set beats clear", 12'h10, 32'h8);
    wr(12'h14, 32'h8);
  endtask

  task automatic t_ignored;
    wr(12'h18, 32'h0);
    wr(12'h10, 32'hF);
    rd_chk("R9 pend write ignored", 12'h10, 32'h0);
    wr(12'h1C, 32'hF);
    rd_chk("R9 msts write ignored", 12'h18, 32'h0);
    check("R9 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_irq_event;
    wr(12'h18, 32'h2);
    pulse(4'b0001);
    check("R6 unmasked event no irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    evt_i = 4'b0010;
    @(negedge clk);
    check("R6 irq after enabled event", {31'b0, irq_o}, 32'h1);
    evt_i = '0;
    rd_chk("R3 msts event", 12'h1C, 32'h2);
    wr(12'h14, 32'h2);
    check("R6 irq after ack", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_mask();
    t_clear();
    t_set_wins();
    t_ignored();
    t_irq_event();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule